// File: doc/BRIEF.md
# Shared SMBus Ownership Semaphore and Port Steering

This block sits between one SMBus host engine and the outside world. It settles who may use the engine, either host software or an on-chip embedded controller (EC), through a single semaphore bit. It also steers the engine's clock and data lines to one of several downstream port pairs. Host software claims the engine by writing a request bit. It then reads the same bit back to learn whether the claim succeeded, and retries while the EC still holds the engine. When it is done, it writes a release bit.

The active port comes from a 2-bit field inside one of two byte-wide select registers. These registers are reached through an index/data pair, and the data location sits one address above the index location. Bit 0 of a third indexed register chooses which of the two select registers supplies the field. A layout input moves the field between two bit positions, so one piece of logic serves both register layouts. A new port choice is applied only while the engine reports idle, so a transfer that is in flight is never cut over to a different port.

Top module: `smbus_share_mux`

## Requirements
- R1: Synchronous active-low reset clears host ownership, EC ownership, the index register and all three select registers, and selects port 0.
- R2: A write to host address 8 with bit 4 set and bit 5 clear, made while the EC does not own the engine, grants the host on that clock edge. From the next cycle, a read of address 8 returns 0x10 and `host_own` is 1.
- R3: A request made while `ec_own` is 1 is not granted: `host_own` stays 0 and bit 4 of address 8 reads 0.
- R4: A write to address 8 with bit 5 set clears host ownership on that edge. When bits 4 and 5 are written together, the release wins.
- R5: `ec_own` rises one cycle after a sampled `ec_req` when the host neither owns the engine nor writes a request (bit 4) in that cycle. It falls one cycle after `ec_req` is sampled low. `host_own` and `ec_own` are never 1 together.
- R6: A write to address 16 sets the index register, and a read of address 16 returns it. Address 17 reads and writes the indexed register, which may be 0x2C, 0x2E or 0x2F. Any other index reads 0x00 and ignores writes, and unlisted addresses read 0x00.
- R7: When bit 0 of indexed register 0x2F is 0, the port field is taken from register 0x2C. When it is 1, the field is taken from register 0x2E.
- R8: With `alt_layout` at 0 the port field is bits 2:1 of the source register. With `alt_layout` at 1 it is bits 4:3.
- R9: `active_port` loads the decoded field on each edge where `eng_idle` is 1, and holds its value on every edge where `eng_idle` is 0.
- R10: Only the active port's `port_scl_oe`/`port_sda_oe` bits follow `eng_scl_oe`/`eng_sda_oe`, and all other ports' bits are 0. `eng_scl_in`/`eng_sda_in` return the active port's line inputs.
- R11: A write to address 8 with neither bit 4 nor bit 5 set leaves the ownership state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | ADDR_W | Host register address |
| reg_wdata | input | 8 | Host write data |
| reg_we | input | 1 | Host write strobe |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| ec_req | input | 1 | EC asks for the engine |
| host_own | output | 1 | Host holds the engine |
| ec_own | output | 1 | EC holds the engine |
| alt_layout | input | 1 | Selects port field at bits 4:3 instead of 2:1 |
| eng_idle | input | 1 | Engine is between transactions |
| active_port | output | PORT_W | Port currently steered |
| eng_scl_oe | input | 1 | Engine clock pull-down enable |
| eng_sda_oe | input | 1 | Engine data pull-down enable |
| eng_scl_in | output | 1 | Clock line seen by the engine |
| eng_sda_in | output | 1 | Data line seen by the engine |
| port_scl_oe | output | NUM_PORTS | Per-port clock pull-down enables |
| port_sda_oe | output | NUM_PORTS | Per-port data pull-down enables |
| port_scl_in | input | NUM_PORTS | Per-port clock line inputs |
| port_sda_in | input | NUM_PORTS | Per-port data line inputs |

## Verification
The bench targets the contested cases of the semaphore. These are a host request while the EC holds the engine, which a wrong design would grant and leave two masters driving the bus, and a combined request-and-release write, which a wrong priority would leave owned. It also targets an EC request in the same cycle as a host request, where both sides could be granted at once. A port change written while `eng_idle` is low must not move `active_port` until idle returns; a mux without that gate would switch lines mid-transfer. The bench also swaps the source register and the field position and checks that bits outside the field and unknown indices do not leak into the port choice.

// File: rtl/smb_share_pkg.sv
// Package: constants shared by the SMBus sharing block.
// Assumes byte-wide registers and a 2-position port field.
package smb_share_pkg;
    localparam int REG_W = 8;
    typedef logic [REG_W-1:0] byte_t;

    // Indexed register numbers; the port logic decodes these.
    localparam byte_t IDX_SEL_A   = 8'h2C;
    localparam byte_t IDX_SEL_B   = 8'h2E;
    localparam byte_t IDX_CHOOSER = 8'h2F;

    // Semaphore bit positions as seen by host software.
    localparam int SEM_REQ_BIT = 4;
    localparam int SEM_REL_BIT = 5;

    // Port field least significant bit per layout.
    localparam int FIELD_LSB_STD = 1;
    localparam int FIELD_LSB_ALT = 3;
endpackage

// File: rtl/smb_sem.sv
// Module: ownership semaphore between host software and the EC.
// Assumes write strobes are single-cycle and already address-decoded.
// Host request is granted only when the EC does not hold the engine;
// release has priority over request.
module smb_sem (
    input  logic clk,
    input  logic rst_n,
    input  logic sem_wr,
    input  logic req_bit,
    input  logic rel_bit,
    input  logic ec_req,
    output logic host_own,
    output logic ec_own
);
    logic host_req_wr;
    logic host_rel_wr;

    // Decode the host's intent for this cycle.
    always_comb begin
        host_req_wr = sem_wr && req_bit;
        host_rel_wr = sem_wr && rel_bit;
    end

    // Host ownership: release wins, request needs an idle EC.
    always_ff @(posedge clk) begin
        if (!rst_n)
            host_own <= 1'b0;
        else if (host_rel_wr)
            host_own <= 1'b0;
        else if (host_req_wr && !ec_own)
            host_own <= 1'b1;
    end

    // EC ownership: taken when free and uncontested, held while requested.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ec_own <= 1'b0;
        else if (!ec_req)
            ec_own <= 1'b0;
        else if (!host_own && !host_req_wr)
            ec_own <= 1'b1;
    end

    a_r5_mutual_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_own && ec_own));

    a_r3_no_grant_ec: assert property (@(posedge clk) disable iff (!rst_n)
        (ec_own && !host_own) |=> !host_own);

    a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
        (sem_wr && rel_bit) |=> !host_own);

    a_r2_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (sem_wr && req_bit && !rel_bit && !ec_own) |=> host_own);
endmodule

// File: rtl/smb_idx_regs.sv
// Module: index/data register file holding the port select bytes.
// Assumes strobes are address-decoded by the parent. Only three index
// values are implemented; others read zero and drop writes.
// Produces the port field from the chosen register and layout.
module smb_idx_regs
    import smb_share_pkg::*;
#(
    parameter int    PORT_W = 2,
    parameter byte_t RST_A  = 8'h00,
    parameter byte_t RST_B  = 8'h00,
    parameter byte_t RST_C  = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_wr,
    input  logic              dat_wr,
    input  byte_t             wdata,
    input  logic              alt_layout,
    output byte_t             idx_q,
    output byte_t             dat_rdata,
    output logic [PORT_W-1:0] port_field
);
    byte_t sel_a_q, sel_b_q, chooser_q;
    byte_t src;

    // Index register load.
    always_ff @(posedge clk) begin
        if (!rst_n)      idx_q <= '0;
        else if (idx_wr) idx_q <= wdata;
    end

    // Indexed register writes; unknown indices are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_a_q   <= RST_A;
            sel_b_q   <= RST_B;
            chooser_q <= RST_C;
        end else if (dat_wr) begin
            case (idx_q)
                IDX_SEL_A:   sel_a_q   <= wdata;
                IDX_SEL_B:   sel_b_q   <= wdata;
                IDX_CHOOSER: chooser_q <= wdata;
                default: ;
            endcase
        end
    end

    // Data window read-back.
    always_comb begin
        case (idx_q)
            IDX_SEL_A:   dat_rdata = sel_a_q;
            IDX_SEL_B:   dat_rdata = sel_b_q;
            IDX_CHOOSER: dat_rdata = chooser_q;
            default:     dat_rdata = '0;
        endcase
    end

    // Source register choice by chooser bit 0.
    always_comb src = chooser_q[0] ? sel_b_q : sel_a_q;

    // Field extraction per bit, position picked by layout.
    for (genvar b = 0; b < PORT_W; b++) begin : g_field
        assign port_field[b] = alt_layout ? src[FIELD_LSB_ALT + b]
                                          : src[FIELD_LSB_STD + b];
    end

    a_r6_unknown_idx: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && idx_q != IDX_SEL_A && idx_q != IDX_SEL_B && idx_q != IDX_CHOOSER)
        |=> ($stable(sel_a_q) && $stable(sel_b_q) && $stable(chooser_q)));
endmodule

// File: rtl/smb_port_mux.sv
// Module: idle-gated port register and 1-of-N open-drain steering.
// Assumes eng_idle is synchronous to clk. Unselected ports never pull low.
module smb_port_mux #(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 eng_idle,
    input  logic [PORT_W-1:0]    port_req,
    output logic [PORT_W-1:0]    active_port,
    input  logic                 eng_scl_oe,
    input  logic                 eng_sda_oe,
    output logic                 eng_scl_in,
    output logic                 eng_sda_in,
    output logic [NUM_PORTS-1:0] port_scl_oe,
    output logic [NUM_PORTS-1:0] port_sda_oe,
    input  logic [NUM_PORTS-1:0] port_scl_in,
    input  logic [NUM_PORTS-1:0] port_sda_in
);
    logic [NUM_PORTS-1:0] hit;

    // Apply a new port only between transactions.
    always_ff @(posedge clk) begin
        if (!rst_n)        active_port <= '0;
        else if (eng_idle) active_port <= port_req;
    end

    // Per-port decode and enable gating.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign hit[p]         = (active_port == PORT_W'(p));
        assign port_scl_oe[p] = hit[p] && eng_scl_oe;
        assign port_sda_oe[p] = hit[p] && eng_sda_oe;
    end

    // Return path: AND-OR of the selected port lines.
    always_comb begin
        eng_scl_in = |(hit & port_scl_in);
        eng_sda_in = |(hit & port_sda_in);
    end

    a_r9_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_idle |=> $stable(active_port));

    a_r9_follow_idle: assert property (@(posedge clk) disable iff (!rst_n)
        eng_idle |=> (active_port == $past(port_req)));

    a_r10_one_scl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_scl_oe));

    a_r10_one_sda: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_sda_oe));
endmodule

// File: rtl/smbus_share_mux.sv
// Module: top of the SMBus sharing block. Decodes the host register
// space, hosts the semaphore, the index/data select registers and the
// port steering. Assumes single-cycle writes and combinational reads.
module smbus_share_mux
    import smb_share_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int SEM_ADDR  = 8,
    parameter int IDX_ADDR  = 16,
    parameter int NUM_PORTS = 4,
    localparam int DAT_ADDR = IDX_ADDR + 1,
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [7:0]           reg_wdata,
    input  logic                 reg_we,
    output logic [7:0]           reg_rdata,
    input  logic                 ec_req,
    output logic                 host_own,
    output logic                 ec_own,
    input  logic                 alt_layout,
    input  logic                 eng_idle,
    output logic [PORT_W-1:0]    active_port,
    input  logic                 eng_scl_oe,
    input  logic                 eng_sda_oe,
    output logic                 eng_scl_in,
    output logic                 eng_sda_in,
    output logic [NUM_PORTS-1:0] port_scl_oe,
    output logic [NUM_PORTS-1:0] port_sda_oe,
    input  logic [NUM_PORTS-1:0] port_scl_in,
    input  logic [NUM_PORTS-1:0] port_sda_in
);
    logic              sem_wr, idx_wr, dat_wr;
    byte_t             idx_q, dat_rdata;
    logic [PORT_W-1:0] port_field;

    // Address decode for write strobes.
    always_comb begin
        sem_wr = reg_we && (reg_addr == ADDR_W'(SEM_ADDR));
        idx_wr = reg_we && (reg_addr == ADDR_W'(IDX_ADDR));
        dat_wr = reg_we && (reg_addr == ADDR_W'(DAT_ADDR));
    end

    smb_sem u_sem (
        .clk      (clk),
        .rst_n    (rst_n),
        .sem_wr   (sem_wr),
        .req_bit  (reg_wdata[SEM_REQ_BIT]),
        .rel_bit  (reg_wdata[SEM_REL_BIT]),
        .ec_req   (ec_req),
        .host_own (host_own),
        .ec_own   (ec_own)
    );

    smb_idx_regs #(.PORT_W(PORT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx_wr     (idx_wr),
        .dat_wr     (dat_wr),
        .wdata      (reg_wdata),
        .alt_layout (alt_layout),
        .idx_q      (idx_q),
        .dat_rdata  (dat_rdata),
        .port_field (port_field)
    );

    smb_port_mux #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_mux (
        .clk         (clk),
        .rst_n       (rst_n),
        .eng_idle    (eng_idle),
        .port_req    (port_field),
        .active_port (active_port),
        .eng_scl_oe  (eng_scl_oe),
        .eng_sda_oe  (eng_sda_oe),
        .eng_scl_in  (eng_scl_in),
        .eng_sda_in  (eng_sda_in),
        .port_scl_oe (port_scl_oe),
        .port_sda_oe (port_sda_oe),
        .port_scl_in (port_scl_in),
        .port_sda_in (port_sda_in)
    );

    // Host read mux.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(SEM_ADDR))
            reg_rdata[SEM_REQ_BIT] = host_own;
        else if (reg_addr == ADDR_W'(IDX_ADDR))
            reg_rdata = idx_q;
        else if (reg_addr == ADDR_W'(DAT_ADDR))
            reg_rdata = dat_rdata;
    end

    a_r11_no_op_write: assert property (@(posedge clk) disable iff (!rst_n)
        (sem_wr && !reg_wdata[SEM_REQ_BIT] && !reg_wdata[SEM_REL_BIT]) |=> $stable(host_own));
endmodule

// File: tb/tb_smbus_share_mux.sv
`timescale 1ns/1ps
module tb_smbus_share_mux;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_rdata;
    logic       ec_req = 1'b0;
    logic       host_own, ec_own;
    logic       alt_layout = 1'b0;
    logic       eng_idle = 1'b1;
    logic [1:0] active_port;
    logic       eng_scl_oe = 1'b0, eng_sda_oe = 1'b0;
    logic       eng_scl_in, eng_sda_in;
    logic [3:0] port_scl_oe, port_sda_oe;
    logic [3:0] port_scl_in = '0, port_sda_in = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    smbus_share_mux dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .ec_req(ec_req),
        .host_own(host_own), .ec_own(ec_own), .alt_layout(alt_layout),
        .eng_idle(eng_idle), .active_port(active_port),
        .eng_scl_oe(eng_scl_oe), .eng_sda_oe(eng_sda_oe),
        .eng_scl_in(eng_scl_in), .eng_sda_in(eng_sda_in),
        .port_scl_oe(port_scl_oe), .port_sda_oe(port_sda_oe),
        .port_scl_in(port_scl_in), .port_sda_in(port_sda_in)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference state, advanced at each rising edge.
    int m_host = 0, m_ec = 0, m_idx = 0, m_port = 0;
    int m_reg [int];

    function automatic int reg_of(input int i);
        if (i == 'h2C || i == 'h2E || i == 'h2F)
            return m_reg.exists(i) ? m_reg[i] : 0;
        return 0;
    endfunction

    always @(posedge clk) begin
        int src, nport, nh, ne;
        if (!rst_n) begin
            m_host = 0; m_ec = 0; m_idx = 0; m_port = 0;
            m_reg.delete();
        end else begin
            src   = reg_of('h2F) % 2 ? reg_of('h2E) : reg_of('h2C);
            nport = alt_layout ? (src / 8) % 4 : (src / 2) % 4;
            nh = m_host; ne = m_ec;
            if (reg_we && reg_addr == 8) begin
                if (reg_wdata[5]) nh = 0;
                else if (reg_wdata[4] && m_ec == 0) nh = 1;
            end
            if (!ec_req) ne = 0;
            else if (m_host == 0 && !(reg_we && reg_addr == 8 && reg_wdata[4])) ne = 1;
            if (reg_we && reg_addr == 17 &&
                (m_idx == 'h2C || m_idx == 'h2E || m_idx == 'h2F))
                m_reg[m_idx] = reg_wdata;
            if (reg_we && reg_addr == 16) m_idx = reg_wdata;
            if (eng_idle) m_port = nport;
            m_host = nh; m_ec = ne;
        end
    end

    // Per-cycle comparison, away from the edge and after input changes.
    always @(negedge clk) begin
        int exp_rd;
        #1;
        if (rst_n && !done) begin
            case (reg_addr)
                5'd8:    exp_rd = m_host * 16;
                5'd16:   exp_rd = m_idx;
                5'd17:   exp_rd = reg_of(m_idx);
                default: exp_rd = 0;
            endcase
            chk("R2 host_own", host_own, m_host);
            chk("R5 ec_own", ec_own, m_ec);
            chk("R6 reg_rdata", reg_rdata, exp_rd);
            chk("R9 active_port", active_port, m_port);
            chk("R10 port_scl_oe", port_scl_oe, eng_scl_oe ? (1 << m_port) : 0);
            chk("R10 port_sda_oe", port_sda_oe, eng_sda_oe ? (1 << m_port) : 0);
            chk("R10 eng_scl_in", eng_scl_in, port_scl_in[m_port]);
            chk("R10 eng_sda_in", eng_sda_in, port_sda_in[m_port]);
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_addr = 5'(a); reg_wdata = 8'(d); reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        #1;
    endtask

    task automatic rd_at(input int a);
        @(negedge clk);
        reg_addr = 5'(a);
        #1;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: reset values
        chk("R1 host_own", host_own, 0);
        chk("R1 ec_own", ec_own, 0);
        chk("R1 active_port", active_port, 0);
        @(negedge clk); rst_n = 1'b1;

        rd_at(17);
        chk("R1 sel reg at index 0", reg_rdata, 0);

        wr(8, 'h10);
        rd_at(8);
        chk("R2 grant readback", reg_rdata, 'h10);

        ec_req = 1'b1;
        idle_cycles(2);
        chk("R5 EC blocked while host owns", ec_own, 0);

        wr(8, 'h20);
        chk("R4 release", host_own, 0);
        idle_cycles(1);
        chk("R5 EC takes free engine", ec_own, 1);

        wr(8, 'h10);
        chk("R3 no grant while EC owns", reg_rdata, 0);

        @(negedge clk); ec_req = 1'b0;
        idle_cycles(1);
        chk("R5 EC drops", ec_own, 0);

        wr(8, 'h30);
        chk("R4 release wins over request", host_own, 0);
        wr(8, 'h01);
        chk("R11 no-op write while free", host_own, 0);
        wr(8, 'h10);
        wr(8, 'h0F);
        chk("R11 no-op write while owned", host_own, 1);

        // Contest: EC request in the cycle of a host request.
        wr(8, 'h20);
        @(negedge clk);
        ec_req = 1'b1; reg_addr = 5'd8; reg_wdata = 8'h10; reg_we = 1'b1;
        @(negedge clk); reg_we = 1'b0; #1;
        chk("R5 host wins same-cycle contest", host_own, 1);
        chk("R5 EC not granted in contest", ec_own, 0);
        wr(8, 'h20);
        @(negedge clk); ec_req = 1'b0;
        idle_cycles(2);

        // Index/data window.
        wr(16, 'h2C);
        wr(17, 'h04);
        rd_at(17);
        chk("R6 readback 0x2C", reg_rdata, 'h04);
        idle_cycles(1);
        chk("R8 std field bits 2:1", active_port, 2);
        wr(16, 'h55);
        wr(17, 'hFF);
        rd_at(17);
        chk("R6 unknown index reads 0", reg_rdata, 0);
        idle_cycles(1);
        chk("R6 unknown write no port effect", active_port, 2);

        @(negedge clk); alt_layout = 1'b1;
        idle_cycles(2);
        chk("R8 alt field of 0x04", active_port, 0);
        wr(16, 'h2C);
        wr(17, 'h18);
        idle_cycles(1);
        chk("R8 alt field of 0x18", active_port, 3);
        @(negedge clk); alt_layout = 1'b0;
        idle_cycles(2);
        chk("R8 std field of 0x18", active_port, 0);

        wr(16, 'h2E);
        wr(17, 'h02);
        idle_cycles(1);
        chk("R7 chooser 0 keeps 0x2C", active_port, 0);
        wr(16, 'h2F);
        wr(17, 'h01);
        idle_cycles(1);
        chk("R7 chooser 1 uses 0x2E", active_port, 1);

        // Busy engine holds the port.
        @(negedge clk); eng_idle = 1'b0;
        wr(17, 'h00);
        idle_cycles(4);
        chk("R9 held while busy", active_port, 1);
        @(negedge clk); eng_idle = 1'b1;
        @(negedge clk); #1;
        chk("R9 applied after idle", active_port, 0);

        // Mux traffic on each port.
        for (int p = 0; p < 4; p++) begin
            wr(16, 'h2C);
            wr(17, p * 2);
            wr(16, 'h2F);
            wr(17, 0);
            idle_cycles(1);
            chk("R10 port steered", active_port, p);
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                eng_scl_oe  = 1'($urandom);
                eng_sda_oe  = 1'($urandom);
                port_scl_in = 4'($urandom);
                port_sda_in = 4'($urandom);
            end
            @(negedge clk);
            eng_scl_oe = 1'b1; eng_sda_oe = 1'b0;
            port_scl_in = 4'(1 << p); port_sda_in = ~4'(1 << p);
            #1;
            chk("R10 only active scl_oe", port_scl_oe, 1 << p);
            chk("R10 sda_oe off", port_sda_oe, 0);
            chk("R10 scl return", eng_scl_in, 1);
            chk("R10 sda return", eng_sda_in, 0);
        end

        idle_cycles(2);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule